// File: doc/BRIEF.md
# Clock-Crossing Register Target on a Multiplexed Bus

This block answers memory read and memory write cycles on a shared bus whose address and data travel on the same wires. It decodes a window of `NREG` 32-bit registers starting at `BASE`. The registers sit in a second clock domain that is asynchronous to the bus. When a cycle hits the window, the block claims it with device-select one clock after the address phase. It then carries each data word to the register domain and back over a toggle request/acknowledge handshake, and each toggle passes through two synchronizing flops. Target-ready stays low until the handshake returns.

The crossing may not return within the 16-clock limit for a data phase. In that case the block raises stop without target-ready. On the first data phase this is a retry, and later in a burst it is a disconnect without data. The launched crossing still completes in the background. When the initiator repeats the same access, the block completes it in the first data cycle and does not copy the word again. Bursts step through the registers in 4-byte increments. The block disconnects with data on the last register of the window.

Top module: `bus_reg_target`

## Requirements
- R1: A cycle whose command is memory read (`cmd_i` = 4'b0110) or memory write (4'b0111), and whose address-phase address lies in [BASE, BASE+4*NREG), gets `devsel_o` high from the clock after the address phase. Any other address or command leaves `devsel_o` low for the whole cycle.
- R2: A write stores the 32-bit word in register (address-BASE)/4. A later read of that address returns it on `rdata_o` in its target-ready cycle.
- R3: After reset `devsel_o`, `trdy_o` and `stop_o` are low and every register reads as zero. A write carrying a non-memory command leaves the registers unchanged.
- R4: In every data phase, `trdy_o` or `stop_o` is raised no later than the 16th clock of that phase. When the crossing is still open at that clock, `stop_o` is raised without `trdy_o`, and on the first data phase this is a retry.
- R5: When a retried access is repeated after its crossing has finished, `trdy_o` rises in the first data clock. For a write, the register keeps the word of the first attempt even if the repeat carries different data.
- R6: Each completed word in a burst advances the register index by one (4 bytes). When the word completed is the last register of the window and the initiator still holds frame, `stop_o` is raised together with `trdy_o`.
- R7: A timeout on a later data phase of a burst raises `stop_o` without `trdy_o`, and the burst ends. Once `stop_o` is high while frame is held, it stays high until frame drops. The word that was abandoned is finished at once when the initiator repeats it.
- R8: `trdy_o` and `stop_o` are only high while `devsel_o` is high. An access that arrives while an unrelated crossing is still open is retried or served and never blocks. Afterwards both the abandoned word and the new one are in effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Bus clock |
| brst_n | input | 1 | Active-low reset, bus domain |
| rclk | input | 1 | Register-domain clock |
| rrst_n | input | 1 | Active-low reset, register domain |
| frame_i | input | 1 | Cycle framing from the initiator, high while more data phases follow |
| irdy_i | input | 1 | Initiator ready |
| cmd_i | input | 4 | Bus command, sampled in the address phase |
| ad_i | input | 32 | Multiplexed address/write data |
| devsel_o | output | 1 | Device-select |
| trdy_o | output | 1 | Target ready |
| stop_o | output | 1 | Stop (retry or disconnect) |
| rdata_o | output | 32 | Read data, valid while `trdy_o` is high on a read |

## Verification
Device-select is due exactly one bus clock after the address phase. The bench samples it one time unit after the falling edge that drives the address, and again after the falling edge of the first data phase. Target-ready and stop are combinational from registered state and `irdy_i`, so the bench drives on the falling edge and samples 1 ns later, counting data clocks from zero in each phase. With the register clock slowed to 80 ns, a crossing needs at least 18 bus clocks, so the stop of R4 and R7 is due at count 15. A repeat of a finished access (R5) is due at count 0. The bench waits 60 to 100 bus clocks before each repeat so the background crossing has closed.

// File: rtl/bus_reg_target.sv
module bus_reg_target #(
  parameter logic [31:0] BASE       = 32'h0000_1000,
  parameter int          NREG       = 8,
  parameter int          WAIT_LIMIT = 16
) (
  input  logic        bclk,
  input  logic        brst_n,
  input  logic        rclk,
  input  logic        rrst_n,
  input  logic        frame_i,
  input  logic        irdy_i,
  input  logic [3:0]  cmd_i,
  input  logic [31:0] ad_i,
  output logic        devsel_o,
  output logic        trdy_o,
  output logic        stop_o,
  output logic [31:0] rdata_o
);
  localparam int          IW      = $clog2(NREG);
  localparam int          CW      = $clog2(WAIT_LIMIT);
  localparam logic [31:0] WIN     = 32'(NREG * 4);
  localparam logic [3:0]  CMD_MRD = 4'b0110;
  localparam logic [3:0]  CMD_MWR = 4'b0111;

  typedef enum logic [1:0] {S_IDLE, S_DATA, S_TERM} st_t;

  st_t            st;
  logic           frame_q;
  logic [IW-1:0]  idx;
  logic           cur_wr;
  logic [CW-1:0]  wcnt;

  logic           x_pend, x_wr, req_t;
  logic [IW-1:0]  x_idx;
  logic [31:0]    x_data;
  logic [1:0]     ack_sync;

  logic [2:0]     req_sync;
  logic           ack_t;
  logic [31:0]    rd_x;
  logic [31:0]    regs [NREG];

  wire [31:0] off     = ad_i - BASE;
  wire        hit     = (ad_i >= BASE) && (off < WIN);
  wire        mem_cmd = (cmd_i == CMD_MRD) || (cmd_i == CMD_MWR);
  wire        addr_ph = (st == S_IDLE) && frame_i && !frame_q;
  wire        x_done  = x_pend && (ack_sync[1] == req_t);
  wire        match   = x_pend && (x_idx == idx) && (x_wr == cur_wr);
  wire        in_data = (st == S_DATA) && irdy_i;
  wire        last    = (idx == IW'(NREG - 1));
  wire        launch  = in_data && !x_pend;
  wire        discard = in_data && x_pend && !match && x_done;
  wire        timeout = (st == S_DATA) && !trdy_o && (wcnt == CW'(WAIT_LIMIT - 1));

  assign trdy_o   = in_data && match && x_done;
  assign stop_o   = (st == S_TERM) || timeout || (trdy_o && last && frame_i);
  assign devsel_o = (st != S_IDLE);
  assign rdata_o  = (trdy_o && !cur_wr) ? rd_x : 32'h0;

  always_ff @(posedge bclk or negedge brst_n) begin
    if (!brst_n) begin
      st       <= S_IDLE;
      frame_q  <= 1'b0;
      idx      <= '0;
      cur_wr   <= 1'b0;
      wcnt     <= '0;
      x_pend   <= 1'b0;
      x_wr     <= 1'b0;
      x_idx    <= '0;
      x_data   <= '0;
      req_t    <= 1'b0;
      ack_sync <= '0;
    end else begin
      frame_q  <= frame_i;
      ack_sync <= {ack_sync[0], ack_t};

      if (launch) begin
        x_pend <= 1'b1;
        x_idx  <= idx;
        x_wr   <= cur_wr;
        x_data <= ad_i;
        req_t  <= ~req_t;
      end else if (trdy_o || discard) begin
        x_pend <= 1'b0;
      end

      case (st)
        S_IDLE: if (addr_ph && hit && mem_cmd) begin
          st     <= S_DATA;
          idx    <= off[IW+1:2];
          cur_wr <= (cmd_i == CMD_MWR);
          wcnt   <= '0;
        end
        S_DATA: if (trdy_o) begin
          wcnt <= '0;
          if (!frame_i)  st <= S_IDLE;
          else if (last) st <= S_TERM;
          else           idx <= idx + 1'b1;
        end else if (timeout) begin
          st <= S_TERM;
        end else begin
          wcnt <= wcnt + 1'b1;
        end
        S_TERM: if (!frame_i) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) begin
      req_sync <= '0;
      ack_t    <= 1'b0;
      rd_x     <= '0;
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else begin
      req_sync <= {req_sync[1:0], req_t};
      if (req_sync[2] ^ req_sync[1]) begin
        if (x_wr) regs[x_idx] <= x_data;
        else      rd_x        <= regs[x_idx];
        ack_t <= ~ack_t;
      end
    end
  end
endmodule

// File: rtl/bus_reg_target_chk.sv
module bus_reg_target_chk #(
  parameter logic [31:0] BASE       = 32'h0000_1000,
  parameter int          NREG       = 8,
  parameter int          WAIT_LIMIT = 16
) (
  input logic        bclk,
  input logic        brst_n,
  input logic        frame_i,
  input logic [3:0]  cmd_i,
  input logic [31:0] ad_i,
  input logic        devsel_o,
  input logic        trdy_o,
  input logic        stop_o
);
  logic fr_q;
  int   wait_cnt;

  wire claim_ok = (ad_i >= BASE) && ((ad_i - BASE) < 32'(NREG * 4)) &&
                  ((cmd_i == 4'b0110) || (cmd_i == 4'b0111));
  wire start    = frame_i && !fr_q && !devsel_o;

  always_ff @(posedge bclk or negedge brst_n) begin
    if (!brst_n) begin
      fr_q     <= 1'b0;
      wait_cnt <= 0;
    end else begin
      fr_q     <= frame_i;
      wait_cnt <= (devsel_o && !trdy_o && !stop_o) ? wait_cnt + 1 : 0;
    end
  end

  assert_claim_R1: assert property (@(posedge bclk) disable iff (!brst_n)
    start && claim_ok |=> devsel_o);

  assert_no_claim_R1: assert property (@(posedge bclk) disable iff (!brst_n)
    start && !claim_ok |=> !devsel_o);

  assert_wait_limit_R4: assert property (@(posedge bclk) disable iff (!brst_n)
    wait_cnt < WAIT_LIMIT);

  assert_stop_held_R7: assert property (@(posedge bclk) disable iff (!brst_n)
    stop_o && frame_i |=> stop_o);

  assert_trdy_in_claim_R8: assert property (@(posedge bclk) disable iff (!brst_n)
    trdy_o |-> devsel_o);

  assert_stop_in_claim_R8: assert property (@(posedge bclk) disable iff (!brst_n)
    stop_o |-> devsel_o);
endmodule

bind bus_reg_target bus_reg_target_chk #(
  .BASE(BASE), .NREG(NREG), .WAIT_LIMIT(WAIT_LIMIT)
) u_chk (
  .bclk(bclk), .brst_n(brst_n), .frame_i(frame_i), .cmd_i(cmd_i), .ad_i(ad_i),
  .devsel_o(devsel_o), .trdy_o(trdy_o), .stop_o(stop_o)
);

// File: tb/bus_reg_target_bench.sv
module bus_reg_target_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [3:0] RD = 4'b0110;
  localparam logic [3:0] WR = 4'b0111;

  typedef struct packed {
    logic [3:0]  cmd;
    logic [31:0] addr;
    logic [31:0] data;
    logic        hit;
  } vec_t;

  localparam vec_t VECS [10] = '{
    '{WR,    32'h0000_1000, 32'hA5A5_0001, 1'b1},
    '{WR,    32'h0000_101C, 32'h0000_7777, 1'b1},
    '{WR,    32'h0000_1008, 32'hDEAD_BEEF, 1'b1},
    '{RD,    32'h0000_1000, 32'hA5A5_0001, 1'b1},
    '{RD,    32'h0000_101C, 32'h0000_7777, 1'b1},
    '{RD,    32'h0000_1008, 32'hDEAD_BEEF, 1'b1},
    '{WR,    32'h0000_1020, 32'h1111_1111, 1'b0},
    '{RD,    32'h0000_0FFC, 32'h0000_0000, 1'b0},
    '{4'h3,  32'h0000_1004, 32'h0000_1234, 1'b0},
    '{RD,    32'h0000_1004, 32'h0000_0000, 1'b1}
  };

  logic bclk = 0, rclk = 0, brst_n = 0, rrst_n = 0;
  logic frame = 0, irdy = 0;
  logic [3:0]  cmd = 0;
  logic [31:0] ad = 0;
  logic devsel_o, trdy_o, stop_o;
  logic [31:0] rdata_o;
  int rclk_half = 4;

  int n_chk = 0, n_fail = 0;
  int kind [8];
  logic [31:0] rdat [8];
  int waits [8];
  int nres;
  logic pre_dsel, first_dsel;

  bus_reg_target u_bus_reg_target (
    .bclk(bclk), .brst_n(brst_n), .rclk(rclk), .rrst_n(rrst_n),
    .frame_i(frame), .irdy_i(irdy), .cmd_i(cmd), .ad_i(ad),
    .devsel_o(devsel_o), .trdy_o(trdy_o), .stop_o(stop_o), .rdata_o(rdata_o)
  );

  initial forever #(CLK_PERIOD/2) bclk = ~bclk;
  initial forever #(rclk_half) rclk = ~rclk;

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog: run hung, actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  task automatic check(input logic ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // kind: 0 = trdy, 1 = trdy with stop, 2 = stop without trdy
  task automatic xact(input logic [3:0] c, input logic [31:0] a,
                      input logic [31:0] d0, input int n);
    int k = 0;
    int w = 0;
    bit fin = 0;
    nres = 0;
    @(negedge bclk); frame = 1; cmd = c; ad = a; irdy = 0;
    #1 pre_dsel = devsel_o;
    @(negedge bclk); irdy = 1; ad = d0; frame = (n > 1);
    #1 first_dsel = devsel_o;
    while (!fin && w < 40) begin
      if (!devsel_o) begin
        w++;
        if (w >= 6) fin = 1;
      end else if (trdy_o || stop_o) begin
        kind[k]  = trdy_o ? (stop_o ? 1 : 0) : 2;
        rdat[k]  = rdata_o;
        waits[k] = w;
        nres     = k + 1;
        if (stop_o || k == n - 1) fin = 1;
        else begin k++; w = 0; end
      end else begin
        w++;
      end
      if (!fin) begin
        @(negedge bclk); ad = d0 + 32'(k); frame = (k < n - 1);
        #1;
      end
    end
    @(negedge bclk); frame = 0; irdy = 0;
    repeat (3) @(negedge bclk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge bclk);
  endtask

  initial begin
    idle(5);
    #1;
    check(!devsel_o && !trdy_o && !stop_o, "R3", "outputs in reset",
          {29'b0, devsel_o, trdy_o, stop_o}, 32'h0);
    brst_n = 1; rrst_n = 1;
    idle(3);

    for (int i = 0; i < 10; i++) begin
      xact(VECS[i].cmd, VECS[i].addr, VECS[i].data, 1);
      if (VECS[i].hit) begin
        check(!pre_dsel && first_dsel, "R1", "devsel one clock after address",
              {30'b0, pre_dsel, first_dsel}, 32'h1);
        check(nres == 1 && kind[0] == 0, "R4", "single word ends with trdy only",
              32'(kind[0]), 32'h0);
        check(waits[0] < 16, "R4", "trdy within wait limit", 32'(waits[0]), 32'd15);
        if (VECS[i].cmd == RD)
          check(rdat[0] == VECS[i].data, (i == 9) ? "R3" : "R2", "read data",
                rdat[0], VECS[i].data);
      end else begin
        check(!first_dsel && nres == 0, "R1", "no claim outside window or command",
              {31'b0, first_dsel}, 32'h0);
      end
    end

    // R6: burst increments the index
    xact(WR, 32'h0000_1010, 32'h0000_0100, 3);
    check(nres == 3 && kind[0] == 0 && kind[1] == 0 && kind[2] == 0, "R6",
          "three-word write burst", 32'(nres), 32'd3);
    xact(RD, 32'h0000_1010, 32'h0, 3);
    for (int k = 0; k < 3; k++)
      check(rdat[k] == 32'h100 + 32'(k), "R6", "burst read word", rdat[k], 32'h100 + 32'(k));

    // R6: disconnect with data at window end
    xact(WR, 32'h0000_1018, 32'h0000_0200, 3);
    check(nres == 2 && kind[0] == 0 && kind[1] == 1, "R6", "stop with trdy on last register",
          32'(kind[1]), 32'd1);
    xact(RD, 32'h0000_1018, 32'h0, 2);
    check(rdat[0] == 32'h200 && rdat[1] == 32'h201, "R6", "window-end words stored",
          rdat[1], 32'h201);

    // R4/R5: slow register domain forces retry, repeat completes at once
    rclk_half = 40;
    idle(10);
    xact(WR, 32'h0000_1004, 32'h0000_0055, 1);
    check(nres == 1 && kind[0] == 2, "R4", "retry when crossing too slow", 32'(kind[0]), 32'd2);
    check(waits[0] == 15, "R4", "stop on 16th data clock", 32'(waits[0]), 32'd15);
    idle(60);
    xact(WR, 32'h0000_1004, 32'h0000_0066, 1);
    check(nres == 1 && kind[0] == 0 && waits[0] == 0, "R5", "repeat finishes in first clock",
          32'(waits[0]), 32'd0);
    rclk_half = 4;
    idle(10);
    xact(RD, 32'h0000_1004, 32'h0, 1);
    check(rdat[0] == 32'h55, "R5", "first-attempt word kept", rdat[0], 32'h55);

    // R7: timeout mid-burst
    rclk_half = 40;
    idle(10);
    xact(WR, 32'h0000_1008, 32'h0000_0077, 1);
    idle(60);
    xact(WR, 32'h0000_1008, 32'h0000_0077, 3);
    check(nres == 2 && kind[0] == 0 && kind[1] == 2, "R7", "disconnect without data",
          32'(kind[1]), 32'd2);
    check(waits[1] == 15, "R7", "mid-burst stop on 16th clock", 32'(waits[1]), 32'd15);
    check(!devsel_o && !stop_o, "R7", "released after frame drop",
          {30'b0, devsel_o, stop_o}, 32'h0);
    idle(60);
    xact(WR, 32'h0000_100C, 32'h0000_0078, 1);
    check(nres == 1 && kind[0] == 0 && waits[0] == 0, "R7", "abandoned word repeated at once",
          32'(waits[0]), 32'd0);
    rclk_half = 4;
    idle(10);
    xact(RD, 32'h0000_1008, 32'h0, 2);
    check(rdat[0] == 32'h77 && rdat[1] == 32'h78, "R7", "burst words stored", rdat[1], 32'h78);

    // R8: unrelated access while a crossing is open
    rclk_half = 40;
    idle(10);
    xact(WR, 32'h0000_1014, 32'h0000_0099, 1);
    xact(RD, 32'h0000_1000, 32'h0, 1);
    check(nres == 1 && kind[0] == 2, "R8", "other access retried, not blocked",
          32'(kind[0]), 32'd2);
    idle(100);
    xact(RD, 32'h0000_1000, 32'h0, 1);
    check(nres == 1 && kind[0] == 0 && rdat[0] == 32'hA5A5_0001, "R8", "repeated read served",
          rdat[0], 32'hA5A5_0001);
    rclk_half = 4;
    idle(10);
    xact(RD, 32'h0000_1014, 32'h0, 1);
    check(rdat[0] == 32'h99, "R8", "abandoned write landed", rdat[0], 32'h99);
    #1;
    check(!devsel_o && !trdy_o && !stop_o, "R8", "idle after access",
          {29'b0, devsel_o, trdy_o, stop_o}, 32'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule